// File: doc/BRIEF.md
# Method Dispatch Puller

This block sits between a command queue and a set of execution engines. Each queue entry holds a method address, a subchannel number and a 32-bit parameter. While pulling is enabled, the block takes the entry at the head of the queue, decides what to do with it, and forwards it to one of four engines over a valid/ready channel. It releases the entry only once the engine has taken it.

Method 0 binds an object to a subchannel. The parameter is a handle. The block sends it to an external lookup unit over a request/acknowledge interface. If the lookup returns a valid entry owned by the current channel, the block does three things: it records the entry's engine as the subchannel's binding, it forwards the object's instance address to that engine as method 0, and it releases the entry.

Methods at 0x100 and above go to the engine that is bound to their subchannel. Within 0x180..0x1FC the parameter is also a handle, and it is replaced by the looked-up instance address before it is forwarded. Methods between 0x004 and 0x0FC are discarded. A failed lookup sets a sticky error flag and discards the entry. Software can read and write the eight subchannel bindings as one 16-bit word.

Top module: `method_puller`

## Requirements
- R1: While `pull_en` is low, no new queue entry is started: `cmd_pop`, `lk_req` and `eng_valid` stay low for every entry not yet begun. Raising `pull_en` resumes processing of the queued entries in order.
- R2: Method 0 sends its parameter as `lk_handle`. After a successful lookup, the block forwards method 0 with `eng_param` = `lk_instance` and `eng_sel` = `lk_engine`, and it writes `lk_engine` into that subchannel's binding.
- R3: Methods 0x180 through 0x1FC have their parameter replaced by `lk_instance`. They go to the engine bound to their subchannel, not to the engine named in the lookup result.
- R4: Methods at 0x100 or above that lie outside 0x180..0x1FC are forwarded with their parameter unchanged to the engine bound to their subchannel. They issue no lookup.
- R5: Methods 0x004 through 0x0FC are removed from the queue without any dispatch or lookup.
- R6: A lookup succeeds only if `lk_hit` is 1 and `lk_chan` equals `chan_id`. When a lookup fails, the block sets `lookup_err`, which then stays set until reset. It also removes the entry without dispatch and leaves the bindings unchanged.
- R7: `bind_rdata` holds subchannel i's 2-bit engine at bits 2i+1:2i and resets to 0. When `bind_we` is pulsed, `bind_wdata` replaces the whole word on the next cycle. A software write takes priority over a bind in the same cycle.
- R8: `last_engine` resets to 0. It takes the `eng_sel` value of each dispatch the engine accepts.
- R9: One entry is handled at a time, in queue order. While `eng_ready` is low, the forwarded command stays valid and unchanged. `cmd_pop` pulses for one cycle only after acceptance, or after a drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pull_en | input | 1 | Allow new entries to be taken |
| chan_id | input | 5 | Current channel, compared with lookup owner |
| cmd_valid | input | 1 | Queue head is present |
| cmd_method | input | 13 | Head method byte address |
| cmd_sub | input | 3 | Head subchannel |
| cmd_param | input | 32 | Head parameter |
| cmd_pop | output | 1 | Remove queue head |
| lk_req | output | 1 | Lookup request, held until acknowledge |
| lk_handle | output | 32 | Handle to look up |
| lk_ack | input | 1 | Lookup result present |
| lk_hit | input | 1 | Looked-up entry is valid |
| lk_chan | input | 5 | Owner channel of the entry |
| lk_engine | input | 2 | Engine of the entry |
| lk_instance | input | 32 | Instance address of the entry |
| eng_valid | output | 1 | Forwarded command is valid |
| eng_ready | input | 1 | Selected engine accepts |
| eng_sel | output | 2 | Target engine |
| eng_sub | output | 3 | Subchannel |
| eng_method | output | 13 | Method byte address |
| eng_param | output | 32 | Forwarded parameter |
| bind_we | input | 1 | Write all bindings |
| bind_wdata | input | 16 | Binding write data |
| bind_rdata | output | 16 | Packed subchannel bindings |
| last_engine | output | 2 | Engine of the last accepted dispatch |
| lookup_err | output | 1 | Sticky failed-lookup flag |

## Verification
The bench probes the edges of both method ranges: 0x0FC/0x100, 0x17C/0x180 and 0x1FC/0x200. A design with an off-by-one range would drop a live method, or it would translate a parameter that should pass through raw. A translated method gets a lookup entry whose engine differs from the subchannel binding. A design that routed by the entry would send that command to the wrong engine. Failed lookups are tested twice, once with an invalid entry and once with a channel mismatch. A design that ignored either case would dispatch a command or change a binding. The engine stalls with a repeating ready pattern, so a design that popped early or let its outputs drift would lose or corrupt commands. Pull is held off while entries are queued, so a design that ignored `pull_en` would drain the queue.

// File: rtl/mp_pkg.sv
package mp_pkg;
  typedef enum logic [1:0] {CL_BIND, CL_DROP, CL_XLATE, CL_PLAIN} mp_cls_e;
  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_SEND, S_POP} mp_state_e;
endpackage

// File: rtl/mp_classify.sv
module mp_classify #(
  parameter int METHOD_W = 13,
  parameter int unsigned ENG_BASE = 'h100,
  parameter int unsigned OBJ_LO = 'h180,
  parameter int unsigned OBJ_HI = 'h1FC
) (
  input  logic [METHOD_W-1:0] method,
  output mp_pkg::mp_cls_e     cls
);
  logic [31:0] m32;
  assign m32 = 32'(method);

  always_comb begin
    if (m32 == 32'd0)                       cls = mp_pkg::CL_BIND;
    else if (m32 < ENG_BASE)                cls = mp_pkg::CL_DROP;
    else if (m32 >= OBJ_LO && m32 <= OBJ_HI) cls = mp_pkg::CL_XLATE;
    else                                    cls = mp_pkg::CL_PLAIN;
  end
endmodule

// File: rtl/mp_bind_table.sv
module mp_bind_table #(
  parameter int SUB_W = 3,
  parameter int ENG_W = 2,
  localparam int NUM_SUB = 1 << SUB_W,
  localparam int BIND_W = NUM_SUB * ENG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BIND_W-1:0] wr_data,
  input  logic              upd_en,
  input  logic [SUB_W-1:0]  upd_sub,
  input  logic [ENG_W-1:0]  upd_eng,
  input  logic [SUB_W-1:0]  rd_sub,
  output logic [ENG_W-1:0]  rd_eng,
  output logic [BIND_W-1:0] packed_q
);
  for (genvar i = 0; i < NUM_SUB; i++) begin : g_slot
    logic [ENG_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst)                                    slot_q <= '0;
      else if (wr_en)                             slot_q <= wr_data[i*ENG_W +: ENG_W];
      else if (upd_en && upd_sub == SUB_W'(i))    slot_q <= upd_eng;
    end
    assign packed_q[i*ENG_W +: ENG_W] = slot_q;
  end

  assign rd_eng = packed_q[rd_sub*ENG_W +: ENG_W];

  // R7
  bind_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> packed_q == $past(wr_data));

  // R2
  bind_update_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !wr_en) |=> packed_q[$past(upd_sub)*ENG_W +: ENG_W] == $past(upd_eng));
endmodule

// File: rtl/method_puller.sv
module method_puller #(
  parameter int METHOD_W = 13,
  parameter int DATA_W = 32,
  parameter int SUB_W = 3,
  parameter int ENG_W = 2,
  parameter int CHAN_W = 5,
  parameter int unsigned ENG_BASE = 'h100,
  parameter int unsigned OBJ_LO = 'h180,
  parameter int unsigned OBJ_HI = 'h1FC,
  localparam int BIND_W = (1 << SUB_W) * ENG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pull_en,
  input  logic [CHAN_W-1:0]   chan_id,
  input  logic                cmd_valid,
  input  logic [METHOD_W-1:0] cmd_method,
  input  logic [SUB_W-1:0]    cmd_sub,
  input  logic [DATA_W-1:0]   cmd_param,
  output logic                cmd_pop,
  output logic                lk_req,
  output logic [DATA_W-1:0]   lk_handle,
  input  logic                lk_ack,
  input  logic                lk_hit,
  input  logic [CHAN_W-1:0]   lk_chan,
  input  logic [ENG_W-1:0]    lk_engine,
  input  logic [DATA_W-1:0]   lk_instance,
  output logic                eng_valid,
  input  logic                eng_ready,
  output logic [ENG_W-1:0]    eng_sel,
  output logic [SUB_W-1:0]    eng_sub,
  output logic [METHOD_W-1:0] eng_method,
  output logic [DATA_W-1:0]   eng_param,
  input  logic                bind_we,
  input  logic [BIND_W-1:0]   bind_wdata,
  output logic [BIND_W-1:0]   bind_rdata,
  output logic [ENG_W-1:0]    last_engine,
  output logic                lookup_err
);
  import mp_pkg::*;

  mp_state_e           st;
  mp_cls_e             head_cls, cls_q;
  logic [METHOD_W-1:0] meth_q;
  logic [SUB_W-1:0]    sub_q;
  logic [DATA_W-1:0]   par_q;
  logic [ENG_W-1:0]    eng_q, head_eng;
  logic                lk_ok, bind_upd;

  mp_classify #(.METHOD_W(METHOD_W), .ENG_BASE(ENG_BASE), .OBJ_LO(OBJ_LO), .OBJ_HI(OBJ_HI))
    u_cls (.method(cmd_method), .cls(head_cls));

  assign lk_ok    = lk_hit && (lk_chan == chan_id);
  assign bind_upd = (st == S_LOOK) && lk_ack && lk_ok && (cls_q == CL_BIND);

  mp_bind_table #(.SUB_W(SUB_W), .ENG_W(ENG_W)) u_bind (
    .clk(clk), .rst(rst),
    .wr_en(bind_we), .wr_data(bind_wdata),
    .upd_en(bind_upd), .upd_sub(sub_q), .upd_eng(lk_engine),
    .rd_sub(cmd_sub), .rd_eng(head_eng),
    .packed_q(bind_rdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      cls_q       <= CL_PLAIN;
      meth_q      <= '0;
      sub_q       <= '0;
      par_q       <= '0;
      eng_q       <= '0;
      last_engine <= '0;
      lookup_err  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (pull_en && cmd_valid) begin
          meth_q <= cmd_method;
          sub_q  <= cmd_sub;
          par_q  <= cmd_param;
          eng_q  <= head_eng;
          cls_q  <= head_cls;
          case (head_cls)
            CL_BIND, CL_XLATE: st <= S_LOOK;
            CL_DROP:           st <= S_POP;
            default:           st <= S_SEND;
          endcase
        end
        S_LOOK: if (lk_ack) begin
          if (!lk_ok) begin
            lookup_err <= 1'b1;
            st         <= S_POP;
          end else begin
            par_q <= lk_instance;
            if (cls_q == CL_BIND) eng_q <= lk_engine;
            st <= S_SEND;
          end
        end
        S_SEND: if (eng_ready) begin
          last_engine <= eng_q;
          st          <= S_POP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_pop    = (st == S_POP);
  assign lk_req     = (st == S_LOOK);
  assign lk_handle  = par_q;
  assign eng_valid  = (st == S_SEND);
  assign eng_sel    = eng_q;
  assign eng_sub    = sub_q;
  assign eng_method = meth_q;
  assign eng_param  = par_q;

  // R1
  pull_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !pull_en) |=> (st == S_IDLE));

  // R5
  no_low_dispatch_chk: assert property (@(posedge clk) disable iff (rst)
    eng_valid |-> (eng_method == '0 || 32'(eng_method) >= ENG_BASE));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    lookup_err |=> lookup_err);

  // R8
  last_engine_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_valid && eng_ready) |=> last_engine == $past(eng_sel));

  // R9
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_valid && !eng_ready) |=> eng_valid && $stable(eng_param) && $stable(eng_sel)
                                  && $stable(eng_method) && $stable(eng_sub));

  // R9
  pop_single_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_pop |=> !cmd_pop);

  // R2
  lookup_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_req && !lk_ack) |=> lk_req && $stable(lk_handle));
endmodule

// File: tb/method_puller_bench.sv
module method_puller_bench;
  logic clk = 0, rst = 1;
  always #4 clk = ~clk;

  logic        pull_en = 0;
  logic [4:0]  chan_id = 5'd3;
  logic        cmd_valid = 0;
  logic [12:0] cmd_method = 0;
  logic [2:0]  cmd_sub = 0;
  logic [31:0] cmd_param = 0;
  logic        cmd_pop, lk_req, lk_ack = 0, lk_hit = 0;
  logic [31:0] lk_handle, lk_instance = 0;
  logic [4:0]  lk_chan = 0;
  logic [1:0]  lk_engine = 0;
  logic        eng_valid, eng_ready = 1;
  logic [1:0]  eng_sel, last_engine;
  logic [2:0]  eng_sub;
  logic [12:0] eng_method;
  logic [31:0] eng_param;
  logic        bind_we = 0;
  logic [15:0] bind_wdata = 0, bind_rdata;
  logic        lookup_err;

  method_puller u_method_puller (.*);

  int checks = 0, fails = 0;
  logic [47:0] fq[$];
  logic [49:0] eq[$];
  string       tq[$];
  logic        stall = 0;
  int          cyc = 0;
  logic [1:0]  last_exp = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void refresh();
    cmd_valid  = (fq.size() > 0);
    cmd_method = cmd_valid ? fq[0][47:35] : '0;
    cmd_sub    = cmd_valid ? fq[0][34:32] : '0;
    cmd_param  = cmd_valid ? fq[0][31:0]  : '0;
  endfunction

  // queue model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    eng_ready <= stall ? (cyc % 3 != 0) : 1'b1;
    if (cmd_pop && fq.size() > 0) begin
      void'(fq.pop_front());
      refresh();
    end
  end

  // lookup model: [31] valid, [28:24] owner, [17:16] engine, [15:0] instance>>4
  always @(posedge clk) begin
    if (rst) lk_ack <= 0;
    else begin
      lk_ack      <= lk_req && !lk_ack;
      lk_hit      <= lk_handle[31];
      lk_chan     <= lk_handle[28:24];
      lk_engine   <= lk_handle[17:16];
      lk_instance <= {12'h0, lk_handle[15:0], 4'h0};
    end
  end

  function automatic logic [31:0] mkh(bit v, logic [4:0] ch, logic [1:0] e, logic [15:0] i);
    return {v, 2'b0, ch, 6'b0, e, i};
  endfunction

  task automatic push(logic [12:0] m, logic [2:0] s, logic [31:0] p);
    fq.push_back({m, s, p});
    refresh();
  endtask

  task automatic expect_out(logic [1:0] e, logic [2:0] s, logic [12:0] m, logic [31:0] p, string tag);
    eq.push_back({e, s, m, p});
    tq.push_back(tag);
    last_exp = e;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && eng_valid && eng_ready) begin
      if (eq.size() == 0) chk(0, "R5 unexpected dispatch", {eng_sel, eng_sub, eng_method, eng_param}, 0);
      else begin
        logic [49:0] e;
        string t;
        e = eq.pop_front();
        t = tq.pop_front();
        chk({eng_sel, eng_sub, eng_method, eng_param} == e, t,
            {eng_sel, eng_sub, eng_method, eng_param}, e);
      end
    end
  end

  task automatic drain();
    while (fq.size() > 0 || eq.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state (R7, R8, R6, R9)
    chk(bind_rdata == 0, "R7 reset bindings", bind_rdata, 0);
    chk(last_engine == 0, "R8 reset last engine", last_engine, 0);
    chk(!lookup_err, "R6 reset error", lookup_err, 0);
    chk(!eng_valid && !cmd_pop, "R9 reset idle", {eng_valid, cmd_pop}, 0);

    // R1: pull off keeps queue intact
    push(13'h104, 3'd0, 32'h1111);
    push(13'h200, 3'd1, 32'h2222);
    repeat (30) @(negedge clk);
    chk(fq.size() == 2, "R1 no pop while pull off", fq.size(), 2);
    expect_out(2'd0, 3'd0, 13'h104, 32'h1111, "R1 resume first");
    expect_out(2'd0, 3'd1, 13'h200, 32'h2222, "R1 resume second");
    pull_en = 1;
    drain();

    // R2: bind subchannel 2 to engine 1
    push(13'h000, 3'd2, mkh(1, 5'd3, 2'd1, 16'h0123));
    expect_out(2'd1, 3'd2, 13'h000, 32'h1230, "R2 bind forward");
    drain();
    chk(bind_rdata[5:4] == 2'd1, "R2 binding stored", bind_rdata, 16'h0010);
    chk(last_engine == 2'd1, "R8 last engine after bind", last_engine, 1);

    // R4 plain and boundaries, with backpressure (R9)
    stall = 1;
    push(13'h200, 3'd2, 32'hDEADBEEF);
    push(13'h17C, 3'd2, 32'h0000ABCD);
    push(13'h100, 3'd0, 32'h5);
    expect_out(2'd1, 3'd2, 13'h200, 32'hDEADBEEF, "R4 plain 0x200 raw");
    expect_out(2'd1, 3'd2, 13'h17C, 32'h0000ABCD, "R4 plain 0x17C raw");
    expect_out(2'd0, 3'd0, 13'h100, 32'h5, "R4 plain 0x100 unbound");
    drain();

    // R3: translated, routed by binding (entry says engine 2)
    push(13'h180, 3'd2, mkh(1, 5'd3, 2'd2, 16'h0044));
    push(13'h1FC, 3'd2, mkh(1, 5'd3, 2'd3, 16'h00F0));
    expect_out(2'd1, 3'd2, 13'h180, 32'h440, "R3 translate 0x180");
    expect_out(2'd1, 3'd2, 13'h1FC, 32'hF00, "R3 translate 0x1FC");
    drain();
    chk(bind_rdata == 16'h0010, "R3 binding untouched", bind_rdata, 16'h0010);
    chk(last_engine == last_exp, "R8 last engine", last_engine, last_exp);
    stall = 0;

    // R5: drops, then a live method still passes
    push(13'h004, 3'd1, 32'h9);
    push(13'h0FC, 3'd1, 32'h9);
    push(13'h300, 3'd2, 32'h77);
    expect_out(2'd1, 3'd2, 13'h300, 32'h77, "R5 after drops");
    drain();
    chk(fq.size() == 0, "R5 drops popped", fq.size(), 0);
    chk(!lookup_err, "R5 no error on drop", lookup_err, 0);

    // R6: invalid entry and channel mismatch
    push(13'h000, 3'd4, mkh(0, 5'd3, 2'd2, 16'h0001));
    drain();
    chk(lookup_err, "R6 invalid sets error", lookup_err, 1);
    chk(bind_rdata == 16'h0010, "R6 binding unchanged invalid", bind_rdata, 16'h0010);
    push(13'h000, 3'd4, mkh(1, 5'd7, 2'd2, 16'h0001));
    push(13'h180, 3'd2, mkh(1, 5'd9, 2'd1, 16'h0002));
    push(13'h400, 3'd2, 32'h42);
    expect_out(2'd1, 3'd2, 13'h400, 32'h42, "R6 after mismatch");
    drain();
    chk(bind_rdata == 16'h0010, "R6 binding unchanged mismatch", bind_rdata, 16'h0010);
    chk(lookup_err, "R6 error sticky", lookup_err, 1);

    // R7: software write of bindings, then routing follows it
    @(negedge clk); bind_we = 1; bind_wdata = 16'hE4C9;
    @(negedge clk); bind_we = 0;
    chk(bind_rdata == 16'hE4C9, "R7 write readback", bind_rdata, 16'hE4C9);
    for (int s = 0; s < 8; s++) begin
      push(13'h300, 3'(s), 32'(s));
      expect_out(2'((16'hE4C9 >> (2 * s)) & 3), 3'(s), 13'h300, 32'(s), "R7 route by written binding");
    end
    drain();
    chk(last_engine == last_exp, "R8 last engine after sweep", last_engine, last_exp);

    finish_run();
  end
endmodule